// File: doc/BRIEF.md
# Serial Transmitter with Automatic Clear-to-Send Gating

The block turns bytes written into a 16-entry transmit queue into asynchronous serial frames on a single output line. Characters of 5 to 8 bits are framed with a low start bit, the data bits least significant first, an optional even or odd parity bit, and a high stop period of 1, 1.5 or 2 bit times. All bit timing comes from a 16x-rate enable pulse, `tick_i`, produced by a baud divider outside the block. Each start, data and parity bit lasts 16 ticks.

When automatic clear-to-send gating is on, the `cts_i` input decides whether a new character may begin. A character that is already on the line always runs to its last stop tick. A break input holds the line low while the shifter keeps running in the background, so the frame timing stays intact. The producer side sees a push port with a full flag. Two status outputs report whether the queue is empty and whether the shifter is idle. The frame settings are latched when each character is loaded.

Top module: `uart_tx_cts`

## Requirements
- R1: After reset, `tx_o` is 1, `fifo_empty_o` is 1, `shift_idle_o` is 1 and `full_o` is 0.
- R2: A frame is one start bit at 0, then the data bits least significant first, then the parity bit if enabled, then the stop period at 1. The start, data and parity bits each last exactly 16 `tick_i` pulses.
- R3: `wlen_i` selects the character length: 0 = 5 bits, 1 = 6, 2 = 7, 3 = 8. Data bits above the selected length are not sent.
- R4: With `par_en_i` = 1 a parity bit is sent. With `par_odd_i` = 0 it makes the count of ones over data and parity even. With `par_odd_i` = 1 it makes that count odd.
- R5: With `stop_long_i` = 0 the stop period is 16 ticks. With `stop_long_i` = 1 it is 24 ticks for 5-bit characters and 32 ticks for 6 to 8 bit characters. `shift_idle_o` rises on the clock after the last stop tick.
- R6: The queue holds 16 characters and sends them in push order. `full_o` is 1 while 16 are stored, and a push made while `full_o` is 1 is dropped.
- R7: With `auto_cts_i` = 1 and `cts_i` = 0, no new start bit is issued and queued characters stay queued. With `auto_cts_i` = 0, `cts_i` has no effect.
- R8: If `cts_i` falls while a character is being sent, that character completes in full, and the next one waits until `cts_i` is 1 again.
- R9: While `break_i` is 1, `tx_o` is 0. Queued characters are still consumed with normal timing.
- R10: `fifo_empty_o` is 1 exactly when no character is queued. `shift_idle_o` is 1 exactly when no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 16x bit-rate enable pulse |
| push_i | input | 1 | Push a character into the queue |
| push_data_i | input | 8 | Character to push |
| full_o | output | 1 | Queue holds 16 characters |
| wlen_i | input | 2 | Character length code (5 + value bits) |
| par_en_i | input | 1 | Parity bit enable |
| par_odd_i | input | 1 | Odd parity when 1, even when 0 |
| stop_long_i | input | 1 | Long stop period (1.5 or 2 bits) |
| auto_cts_i | input | 1 | Enable clear-to-send gating |
| cts_i | input | 1 | Clear to send, active high |
| break_i | input | 1 | Force line low |
| tx_o | output | 1 | Serial output line |
| fifo_empty_o | output | 1 | Queue is empty |
| shift_idle_o | output | 1 | No frame in progress |

## Verification
Frames are decoded at the centre of each bit for several settings:
- 8 bits without parity, using the bytes 0x55, 0xA3, 0x00, 0xFF and 0x81. The alternating and all-equal patterns catch bit-order and shift errors.
- 7 bits with even parity, where bit 7 of the pushed byte is set. This shows whether bits above the selected length are masked.
- 5 bits with odd parity and a long stop, and 6 and 8 bits with a long stop. The frame length measured to the rise of `shift_idle_o` tells the 16, 24 and 32 tick stop periods apart.

Further runs check the flow-control and queue behaviour:
- Holding off clear-to-send with two characters queued, then releasing it for one start and dropping it again mid-frame. This separates gating at character boundaries from a cut-off frame.
- Seventeen pushes against a stalled line, which expose a queue that overwrites or accepts past 16.
- A break held across a whole character, which shows that the line stays low while the queue still drains.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int CHAR_W    = 8;
  localparam int BIT_TICKS = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       par_odd;
    logic       stop_long;
  } tx_cfg_t;
endpackage

// File: rtl/tx_fifo.sv
module tx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign data_o  = mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> $stable(cnt));
  assert_flags_exclusive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
  import uart_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              avail_i,
  input  logic [CHAR_W-1:0] data_i,
  input  tx_cfg_t           cfg_i,
  input  logic              auto_cts_i,
  input  logic              cts_i,
  output logic              pop_o,
  output logic              line_o,
  output logic              idle_o
);
  tx_state_e         state;
  tx_cfg_t           cfg_q;
  logic [4:0]        cnt;
  logic [2:0]        idx;
  logic [CHAR_W-1:0] shreg;
  logic              par_q;

  logic [3:0]        nbits_in, nbits_q;
  logic [CHAR_W-1:0] masked;
  logic              par_bit, go, bit_end, last_bit;
  logic [5:0]        lim;

  assign nbits_in = 4'd5 + {2'b00, cfg_i.wlen};
  assign nbits_q  = 4'd5 + {2'b00, cfg_q.wlen};

  always_comb begin
    masked = data_i;
    for (int i = 5; i < CHAR_W; i++)
      if (i >= int'(nbits_in)) masked[i] = 1'b0;
    par_bit = (^masked) ^ cfg_i.par_odd;
  end

  // stop period: 16, or 24 for 5-bit characters, or 32
  always_comb begin
    lim = 6'(BIT_TICKS);
    if (state == ST_STOP && cfg_q.stop_long)
      lim = (cfg_q.wlen == 2'd0) ? 6'd24 : 6'd32;
  end

  assign go       = (state == ST_IDLE) && avail_i && (!auto_cts_i || cts_i);
  assign pop_o    = go;
  assign bit_end  = tick_i && ({1'b0, cnt} == lim - 6'd1);
  assign last_bit = (idx == 3'(nbits_q - 4'd1));
  assign idle_o   = (state == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_IDLE;
      cfg_q <= '0;
      cnt   <= '0;
      idx   <= '0;
      shreg <= '0;
      par_q <= 1'b0;
    end else if (state == ST_IDLE) begin
      if (go) begin
        state <= ST_START;
        cfg_q <= cfg_i;
        cnt   <= '0;
        idx   <= '0;
        shreg <= data_i;
        par_q <= par_bit;
      end
    end else if (tick_i) begin
      if (bit_end) begin
        cnt <= '0;
        case (state)
          ST_START: state <= ST_DATA;
          ST_DATA: begin
            if (last_bit) state <= cfg_q.par_en ? ST_PAR : ST_STOP;
            else begin
              shreg <= shreg >> 1;
              idx   <= idx + 1'b1;
            end
          end
          ST_PAR:  state <= ST_STOP;
          default: state <= ST_IDLE;
        endcase
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    case (state)
      ST_START: line_o = 1'b0;
      ST_DATA:  line_o = shreg[0];
      ST_PAR:   line_o = par_q;
      default:  line_o = 1'b1;
    endcase
  end

  assert_cts_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE && auto_cts_i && !cts_i) |=> (state == ST_IDLE));
  assert_hold_without_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != ST_IDLE && !tick_i) |=> ($stable(state) && $stable(cnt)));
  assert_pop_needs_data_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |-> avail_i);
  assert_busy_not_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |=> !idle_o);
endmodule

// File: rtl/uart_tx_cts.sv
module uart_tx_cts
  import uart_tx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              push_i,
  input  logic [CHAR_W-1:0] push_data_i,
  output logic              full_o,
  input  logic [1:0]        wlen_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              stop_long_i,
  input  logic              auto_cts_i,
  input  logic              cts_i,
  input  logic              break_i,
  output logic              tx_o,
  output logic              fifo_empty_o,
  output logic              shift_idle_o
);
  logic [CHAR_W-1:0] head;
  logic              pop, line;
  tx_cfg_t           cfg;

  assign cfg = '{wlen: wlen_i, par_en: par_en_i, par_odd: par_odd_i, stop_long: stop_long_i};

  tx_fifo #(.DW(CHAR_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push_i),
    .data_i  (push_data_i),
    .pop_i   (pop),
    .data_o  (head),
    .full_o  (full_o),
    .empty_o (fifo_empty_o)
  );

  tx_shifter u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .avail_i    (~fifo_empty_o),
    .data_i     (head),
    .cfg_i      (cfg),
    .auto_cts_i (auto_cts_i),
    .cts_i      (cts_i),
    .pop_o      (pop),
    .line_o     (line),
    .idle_o     (shift_idle_o)
  );

  // break overrides the line; shifter keeps its timing
  assign tx_o = line & ~break_i;

  assert_idle_line_high_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_idle_o && !break_i) |-> tx_o);
endmodule

// File: tb/uart_tx_cts_test.sv
module uart_tx_cts_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       push_i = 1'b0;
  logic [7:0] push_data_i = '0;
  logic [1:0] wlen_i = 2'd3;
  logic       par_en_i = 1'b0, par_odd_i = 1'b0, stop_long_i = 1'b0;
  logic       auto_cts_i = 1'b0, cts_i = 1'b0, break_i = 1'b0;
  logic       full_o, tx_o, fifo_empty_o, shift_idle_o;

  int         n_chk = 0, n_err = 0;
  logic [7:0] exp_q[$];
  bit         mon_en = 1'b1;
  bit         done = 1'b0;

  always #2 clk_i = ~clk_i;

  uart_tx_cts uut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      #1 tick_i = ~tick_i;
    end
  end

  task automatic push(input logic [7:0] d, output bit acc);
    @(posedge clk_i); #1;
    push_i = 1'b1;
    push_data_i = d;
    acc = !full_o;
    if (acc) exp_q.push_back(d);
    @(posedge clk_i); #1;
    push_i = 1'b0;
  endtask

  task automatic push_list(input logic [7:0] d[]);
    bit acc;
    foreach (d[i]) push(d[i], acc);
  endtask

  task automatic set_cfg(input logic [1:0] wl, input bit pe, input bit po, input bit sl);
    @(posedge clk_i); #1;
    wlen_i = wl; par_en_i = pe; par_odd_i = po; stop_long_i = sl;
  endtask

  task automatic wait_idle();
    do @(negedge clk_i); while (!(fifo_empty_o && shift_idle_o));
    repeat (2) @(negedge clk_i);
  endtask

  // receiver model: samples each bit at its 8th tick, measures frame length
  task automatic decode();
    int wl, nb, stop_t, total, cnt, b;
    bit p;
    logic [7:0] d;
    logic [11:0] fb;
    wl = 5 + int'(wlen_i);
    p = par_en_i;
    nb = 1 + wl + int'(p);
    stop_t = !stop_long_i ? 16 : (wl == 5 ? 24 : 32);
    total = 16 * nb + stop_t;
    if (exp_q.size() == 0) begin
      check(1'b0, "R6 unexpected frame", 1, 0);
      d = '0;
    end else d = exp_q.pop_front();
    fb = '0;
    for (int i = 0; i < wl; i++) fb[1+i] = d[i];
    if (p) fb[1+wl] = (^(d & 8'((1 << wl) - 1))) ^ par_odd_i;
    fb[nb] = 1'b1;
    cnt = 0;
    forever begin
      if (tick_i) begin
        cnt++;
        if (cnt % 16 == 8 && cnt / 16 <= nb) begin
          b = cnt / 16;
          if (b == 0)            check(tx_o == 1'b0, "R2 start bit", tx_o, 0);
          else if (b <= wl)      check(tx_o == fb[b], "R3 data bit", tx_o, fb[b]);
          else if (p && b == wl + 1) check(tx_o == fb[b], "R4 parity bit", tx_o, fb[b]);
          else                   check(tx_o == 1'b1, "R2 stop bit", tx_o, 1);
        end
        if (cnt == total) break;
      end
      @(negedge clk_i);
    end
    check(shift_idle_o == 1'b0, "R5 stop too short", shift_idle_o, 0);
    @(negedge clk_i);
    check(shift_idle_o == 1'b1, "R5 stop too long", shift_idle_o, 1);
  endtask

  initial begin
    bit prev = 1'b1;
    forever begin
      @(negedge clk_i);
      if (mon_en && rst_ni && prev && !tx_o) decode();
      prev = tx_o;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    bit acc;
    int n_acc;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check(tx_o == 1'b1, "R1 tx_o", tx_o, 1);
    check(fifo_empty_o == 1'b1, "R1 fifo_empty_o", fifo_empty_o, 1);
    check(shift_idle_o == 1'b1, "R1 shift_idle_o", shift_idle_o, 1);
    check(full_o == 1'b0, "R1 full_o", full_o, 0);
    @(posedge clk_i); #1 rst_ni = 1'b1;

    // 8 bits, no parity, 1 stop
    set_cfg(2'd3, 0, 0, 0);
    push_list('{8'h55, 8'hA3, 8'h00, 8'hFF, 8'h81});
    wait_idle();
    // 7 bits even parity, bit 7 must be dropped (R3)
    set_cfg(2'd2, 1, 0, 0);
    push_list('{8'h7F, 8'h8A, 8'hC5});
    wait_idle();
    // 5 bits odd parity, 1.5 stop (R5)
    set_cfg(2'd0, 1, 1, 1);
    push_list('{8'h1F, 8'hE3, 8'h04});
    wait_idle();
    // 6 bits no parity, 2 stop
    set_cfg(2'd1, 0, 0, 1);
    push_list('{8'h2A, 8'h15});
    wait_idle();
    // 8 bits odd parity, 2 stop
    set_cfg(2'd3, 1, 1, 1);
    push_list('{8'h96, 8'h00});
    wait_idle();
    check(exp_q.size() == 0, "R6 all frames sent", exp_q.size(), 0);

    // CTS gating (R7, R8)
    set_cfg(2'd3, 0, 0, 0);
    auto_cts_i = 1'b1; cts_i = 1'b0;
    push_list('{8'h11, 8'h22});
    repeat (200) @(negedge clk_i);
    check(tx_o == 1'b1, "R7 no start while cts low", tx_o, 1);
    check(fifo_empty_o == 1'b0, "R7 data held in queue", fifo_empty_o, 0);
    check(shift_idle_o == 1'b1, "R7 shifter idle while cts low", shift_idle_o, 1);
    cts_i = 1'b1;
    do @(negedge clk_i); while (tx_o);
    cts_i = 1'b0;
    repeat (800) @(negedge clk_i);
    check(exp_q.size() == 1, "R8 one frame completed", exp_q.size(), 1);
    check(fifo_empty_o == 1'b0, "R8 next frame waits", fifo_empty_o, 0);
    check(tx_o == 1'b1, "R8 line idle after frame", tx_o, 1);
    cts_i = 1'b1;
    wait_idle();
    check(exp_q.size() == 0, "R8 held frame sent after cts", exp_q.size(), 0);
    auto_cts_i = 1'b0; cts_i = 1'b0;
    push_list('{8'h33});
    wait_idle();
    check(exp_q.size() == 0, "R7 cts ignored without auto", exp_q.size(), 0);

    // queue depth and overflow drop (R6)
    auto_cts_i = 1'b1; cts_i = 1'b0;
    n_acc = 0;
    for (int i = 0; i < 16; i++) begin
      push(8'(i * 13 + 7), acc);
      n_acc += int'(acc);
    end
    @(negedge clk_i);
    check(full_o == 1'b1, "R6 full after 16", full_o, 1);
    check(n_acc == 16, "R6 16 accepted", n_acc, 16);
    push(8'hEE, acc);
    check(acc == 1'b0, "R6 17th push dropped", acc, 0);
    @(posedge clk_i); #1 cts_i = 1'b1;
    wait_idle();
    check(exp_q.size() == 0, "R6 order and count", exp_q.size(), 0);
    auto_cts_i = 1'b0;

    // break (R9)
    mon_en = 1'b0;
    @(posedge clk_i); #1 break_i = 1'b1;
    repeat (5) @(negedge clk_i);
    check(tx_o == 1'b0, "R9 break drives low", tx_o, 0);
    push_list('{8'hFF});
    begin
      bit any_high = 1'b0;
      do begin
        @(negedge clk_i);
        if (tx_o) any_high = 1'b1;
      end while (!(fifo_empty_o && shift_idle_o));
      check(any_high == 1'b0, "R9 line low through frame", any_high, 0);
    end
    check(fifo_empty_o == 1'b1, "R9 char consumed under break", fifo_empty_o, 1);
    void'(exp_q.pop_front());
    @(posedge clk_i); #1 break_i = 1'b0;
    @(negedge clk_i);
    check(tx_o == 1'b1, "R9 line released", tx_o, 1);
    mon_en = 1'b1;

    done = 1'b1;
    finish_run();
  end
endmodule